// File: doc/BRIEF.md
# Interrupt Router Indirect Register Port

This block is the bus-facing register front end of an I/O interrupt router. Software never addresses the routing table directly. It first writes an 8-bit selector into a select register. It then reads or writes a single 32-bit data window, and the selector decides what the window reaches. A selector can reach a version word, a 4-bit router ID, an arbitration word that mirrors the ID, or one 32-bit half of a 64-bit routing entry. There is one routing entry per interrupt pin.

Bus accesses carry a size code for 1, 2, 4 or 8 bytes at aligned offsets. Only two offsets decode: the select register and the data window. The block holds the routing table and exposes each entry's mask, trigger-mode and remote-IRR bits to the pin-service logic. The delivery logic sets remote-IRR through a per-pin input. Whenever a window write flips an entry's mask or trigger-mode bit, the block raises a one-cycle change pulse that carries the pin index and the new values. Delivery and end-of-interrupt processing are left to the neighbouring blocks.

Top module: `irq_regport`

## Requirements
- R1: A write to offset 0x00 stores bits 7:0 of the size-masked write data as the selector. A read of offset 0x00 returns the selector zero-extended.
- R2: With selector 0x00, the window reads (NUM_PINS-1) in bits 23:16 and VERSION in bits 7:0, with all other bits zero. Window writes with this selector change nothing.
- R3: Selectors 0x01 and 0x02 both read the 4-bit ID in bits 27:24. A window write with selector 0x01 loads the ID from data bits 27:24. A window write with selector 0x02 is ignored.
- R4: For selectors 0x10 and above, the entry index is (selector-0x10)>>1. Selector bit 0 picks the upper 32 bits (1) or the lower 32 bits (0) of that 64-bit entry, for both reads and writes.
- R5: If the selector is below 0x10, or the index is NUM_PINS or more, a window read returns 0xFFFFFFFF and a window write alters no entry.
- R6: Entry bit 14 is remote-IRR. It is set by a pulse on remote_set[i]. Any low-half write to entry i stores bit 14 as 0, whatever the data holds, and wins over a set in the same cycle. Upper-half writes leave it alone.
- R7: Offsets other than 0x00 and 0x10 read as 0 and ignore writes.
- R8: Size code 0/1/2/3 means 1/2/4/8 bytes. Write data is cut to its low 8/16/32/32 bits. Read data is returned in its low 8/16/32/32 bits, and the upper bits of bus_rdata are zero.
- R9: After reset, every entry reads 0x00010000 in its low half (mask bit 16 set) and 0 in its upper half. The selector and the ID are 0, and no change pulse is active.
- R10: A window write that changes an entry's mask bit (16) or trigger bit (15) sets chg_valid for exactly the next cycle, with chg_pin, chg_mask and chg_level giving the entry and its new bits. A write that changes neither bit raises no pulse.
- R11: bus_rvalid and bus_rdata appear one cycle after bus_rd and reflect the state before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset within the mapped region |
| bus_size | input | 2 | Access size code (0:1B, 1:2B, 2:4B, 3:8B) |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| remote_set | input | NUM_PINS | Per-pin set of remote-IRR from delivery logic |
| pin_mask | output | NUM_PINS | Mask bit of each entry |
| pin_level | output | NUM_PINS | Trigger-mode bit of each entry (1 = level) |
| pin_remote | output | NUM_PINS | Remote-IRR bit of each entry |
| chg_valid | output | 1 | One-cycle mask/trigger change pulse |
| chg_pin | output | PW | Entry index of the change |
| chg_mask | output | 1 | New mask bit |
| chg_level | output | 1 | New trigger-mode bit |

## Verification
The bench builds the block with its default values: NUM_PINS of 24 and VERSION of 0x20. With these values the last entry sits at selectors 0x3E/0x3F, and the first out-of-range selector is 0x40. That puts the upper edge of the table, the region below 0x10 and the version field (0x17 in bits 23:16) within reach of directed accesses. Size-masked reads and writes are exercised on a single entry, so truncation of both data paths shows in the readback.

// File: rtl/irq_regport.sv
module irq_regport #(
  parameter int NUM_PINS = 24,
  parameter logic [7:0] VERSION = 8'h20,
  localparam int PW = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [7:0]          bus_addr,
  input  logic [1:0]          bus_size,
  input  logic [63:0]         bus_wdata,
  output logic [63:0]         bus_rdata,
  output logic                bus_rvalid,
  input  logic [NUM_PINS-1:0] remote_set,
  output logic [NUM_PINS-1:0] pin_mask,
  output logic [NUM_PINS-1:0] pin_level,
  output logic [NUM_PINS-1:0] pin_remote,
  output logic                chg_valid,
  output logic [PW-1:0]       chg_pin,
  output logic                chg_mask,
  output logic                chg_level
);

  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;
  localparam logic [7:0] PMAX    = 8'(NUM_PINS - 1);

  logic [7:0]  sel_q;
  logic [3:0]  id_q;
  logic [63:0] tbl [NUM_PINS];

  logic [31:0] wd;
  always_comb begin
    case (bus_size)
      2'd0:    wd = {24'h0, bus_wdata[7:0]};
      2'd1:    wd = {16'h0, bus_wdata[15:0]};
      default: wd = bus_wdata[31:0];
    endcase
  end

  logic [7:0]    off;
  logic          tab_ok;
  logic [PW-1:0] idx;
  logic          hi_half;
  assign off     = sel_q - 8'h10;
  assign tab_ok  = (sel_q >= 8'h10) && ({1'b0, off[7:1]} < 8'(NUM_PINS));
  assign idx     = off[PW:1];
  assign hi_half = sel_q[0];

  logic wr_sel, wr_win, wr_ent;
  assign wr_sel = bus_wr && (bus_addr == OFF_SEL);
  assign wr_win = bus_wr && (bus_addr == OFF_WIN);
  assign wr_ent = wr_win && tab_ok;

  logic [31:0] win_val;
  always_comb begin
    case (sel_q)
      8'h00:       win_val = {8'h0, PMAX, 8'h0, VERSION};
      8'h01, 8'h02: win_val = {4'h0, id_q, 24'h0};
      default:     win_val = !tab_ok ? 32'hFFFF_FFFF :
                             hi_half ? tbl[idx][63:32] : tbl[idx][31:0];
    endcase
  end

  logic [31:0] raw;
  assign raw = (bus_addr == OFF_SEL) ? {24'h0, sel_q} :
               (bus_addr == OFF_WIN) ? win_val : 32'h0;

  logic [63:0] rd_val;
  always_comb begin
    case (bus_size)
      2'd0:    rd_val = {56'h0, raw[7:0]};
      2'd1:    rd_val = {48'h0, raw[15:0]};
      default: rd_val = {32'h0, raw};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (wr_sel) sel_q <= wd[7:0];
      if (wr_win && sel_q == 8'h01) id_q <= wd[27:24];
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tbl[i] <= 64'h0000_0000_0001_0000;
      end else begin
        if (remote_set[i]) tbl[i][14] <= 1'b1;
        if (wr_ent && idx == PW'(i)) begin
          if (hi_half) tbl[i][63:32] <= wd;
          else         tbl[i][31:0]  <= {wd[31:15], 1'b0, wd[13:0]};
        end
      end
    end
    assign pin_mask[i]   = tbl[i][16];
    assign pin_level[i]  = tbl[i][15];
    assign pin_remote[i] = tbl[i][14];
  end

  logic flip;
  assign flip = wr_ent && !hi_half &&
                ((tbl[idx][16] != wd[16]) || (tbl[idx][15] != wd[15]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chg_valid <= 1'b0;
      chg_pin   <= '0;
      chg_mask  <= 1'b0;
      chg_level <= 1'b0;
    end else begin
      chg_valid <= flip;
      if (flip) begin
        chg_pin   <= idx;
        chg_mask  <= wd[16];
        chg_level <= wd[15];
      end
    end
  end

endmodule

// File: rtl/irq_regport_chk.sv
module irq_regport_chk #(
  parameter int NUM_PINS = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [7:0]          bus_addr,
  input logic [63:0]         bus_wdata,
  input logic                bus_rvalid,
  input logic [7:0]          sel_q,
  input logic [3:0]          id_q,
  input logic [NUM_PINS-1:0] pin_mask,
  input logic [NUM_PINS-1:0] pin_level,
  input logic [NUM_PINS-1:0] pin_remote,
  input logic                chg_valid
);

  logic [7:0] c_off;
  logic       c_oor;
  assign c_off = sel_q - 8'h10;
  assign c_oor = (sel_q < 8'h10) || ({1'b0, c_off[7:1]} >= 8'(NUM_PINS));

  logic win_w;
  assign win_w = bus_wr && bus_addr == 8'h10;

  p_sel_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 8'h00 |=> sel_q == $past(bus_wdata[7:0]));

  p_arb_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_w && sel_q == 8'h02 |=> $stable(id_q));

  p_oor_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_w && c_oor |=> $stable(pin_mask) && $stable(pin_level));

  p_low_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_w && sel_q == 8'h10 |=> !pin_remote[0]);

  p_other_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr != 8'h00 && bus_addr != 8'h10 |=>
      $stable(sel_q) && $stable(id_q) && $stable(pin_mask) && $stable(pin_level));

  p_chg_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    chg_valid |-> $past(win_w));

  p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  p_rvalid_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

endmodule

bind irq_regport irq_regport_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
  .sel_q(sel_q), .id_q(id_q), .pin_mask(pin_mask), .pin_level(pin_level),
  .pin_remote(pin_remote), .chg_valid(chg_valid)
);

// File: tb/irq_regport_tb.sv
module irq_regport_tb;
  localparam int NP = 24;
  localparam int PW = $clog2(NP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [1:0] bus_size = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic bus_rvalid;
  logic [NP-1:0] remote_set = '0;
  logic [NP-1:0] pin_mask, pin_level, pin_remote;
  logic chg_valid, chg_mask, chg_level;
  logic [PW-1:0] chg_pin;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  irq_regport u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .remote_set(remote_set),
    .pin_mask(pin_mask), .pin_level(pin_level), .pin_remote(pin_remote),
    .chg_valid(chg_valid), .chg_pin(chg_pin), .chg_mask(chg_mask),
    .chg_level(chg_level)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [1:0] s, logic [63:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [1:0] s, output logic [63:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_size = s;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R11 rvalid", {63'h0, bus_rvalid}, 64'h1);
    v = bus_rdata;
  endtask

  task automatic rd_win(logic [7:0] sel, output logic [63:0] v);
    wr(8'h00, 2'd2, {56'h0, sel});
    rd(8'h10, 2'd2, v);
  endtask

  task automatic wr_win(logic [7:0] sel, logic [31:0] d);
    wr(8'h00, 2'd2, {56'h0, sel});
    wr(8'h10, 2'd2, {32'h0, d});
  endtask

  task automatic t_reset;
    logic [63:0] v;
    chk("R9 mask all set", {40'h0, pin_mask}, {40'h0, {NP{1'b1}}});
    chk("R9 remote clear", {40'h0, pin_remote}, 64'h0);
    chk("R9 no pulse", {63'h0, chg_valid}, 64'h0);
    rd(8'h00, 2'd2, v); chk("R9 selector zero", v, 64'h0);
    rd(8'h10, 2'd2, v); chk("R9 version via sel 0", v, 64'h0017_0020);
    rd_win(8'h01, v); chk("R9 id zero", v, 64'h0);
    rd_win(8'h2C, v); chk("R9 entry 14 low", v, 64'h0001_0000);
    rd_win(8'h2D, v); chk("R9 entry 14 high", v, 64'h0);
  endtask

  task automatic t_select;
    logic [63:0] v;
    wr(8'h00, 2'd3, 64'h1234_5678_9ABC_DE33);
    rd(8'h00, 2'd1, v); chk("R1 selector low 8 bits", v, 64'h33);
  endtask

  task automatic t_version;
    logic [63:0] v;
    wr_win(8'h00, 32'hFFFF_FFFF);
    rd(8'h10, 2'd2, v); chk("R2 version after write", v, 64'h0017_0020);
  endtask

  task automatic t_id;
    logic [63:0] v;
    wr_win(8'h01, 32'hA500_0000);
    rd(8'h10, 2'd2, v); chk("R3 id read", v, 64'h0500_0000);
    rd_win(8'h02, v); chk("R3 arb mirrors id", v, 64'h0500_0000);
    wr(8'h10, 2'd2, 64'h0F00_0000);
    rd(8'h10, 2'd2, v); chk("R3 arb write ignored", v, 64'h0500_0000);
  endtask

  task automatic t_table;
    logic [63:0] v;
    wr(8'h00, 2'd2, 64'h16);
    wr(8'h10, 2'd2, 64'h0001_C0AB);
    chk("R10 pulse on level flip", {63'h0, chg_valid}, 64'h1);
    chk("R10 pulse pin", {59'h0, chg_pin}, 64'd3);
    chk("R10 pulse bits", {62'h0, chg_mask, chg_level}, 64'h3);
    @(negedge clk);
    chk("R10 pulse one cycle", {63'h0, chg_valid}, 64'h0);
    rd(8'h10, 2'd2, v); chk("R4 entry 3 low (R6 bit 14 dropped)", v, 64'h0001_80AB);
    chk("R4 entry 3 level out", {63'h0, pin_level[3]}, 64'h1);
    wr_win(8'h17, 32'hC000_0000);
    chk("R10 no pulse on high half", {63'h0, chg_valid}, 64'h0);
    rd(8'h10, 2'd2, v); chk("R4 entry 3 high", v, 64'hC000_0000);
    wr_win(8'h3F, 32'hDEAD_BEEF);
    rd(8'h10, 2'd2, v); chk("R4 last entry high", v, 64'hDEAD_BEEF);
    rd_win(8'h3E, v); chk("R4 last entry low untouched", v, 64'h0001_0000);
  endtask

  task automatic t_oor;
    logic [63:0] v;
    rd_win(8'h40, v); chk("R5 read past table", v, 64'hFFFF_FFFF);
    rd_win(8'h41, v); chk("R5 read past table high", v, 64'hFFFF_FFFF);
    rd_win(8'h05, v); chk("R5 read below table", v, 64'hFFFF_FFFF);
    wr_win(8'h40, 32'h0);
    chk("R5 write dropped masks", {40'h0, pin_mask}, {40'h0, {NP{1'b1}}});
    rd_win(8'h3E, v); chk("R5 last entry unchanged", v, 64'h0001_0000);
  endtask

  task automatic t_remote;
    logic [63:0] v;
    @(negedge clk); remote_set = 24'h4;
    @(negedge clk); remote_set = '0;
    chk("R6 remote set", {63'h0, pin_remote[2]}, 64'h1);
    rd_win(8'h14, v); chk("R6 bit 14 readback", v, 64'h0001_4000);
    wr_win(8'h15, 32'h1111_1111);
    chk("R6 high write keeps", {63'h0, pin_remote[2]}, 64'h1);
    wr_win(8'h14, 32'h0001_4000);
    chk("R6 low write clears", {63'h0, pin_remote[2]}, 64'h0);
    chk("R10 no pulse when bits equal", {63'h0, chg_valid}, 64'h0);
    wr(8'h00, 2'd2, 64'h14);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h10; bus_size = 2'd2; bus_wdata = 64'h0001_0000;
    remote_set = 24'h4;
    @(negedge clk);
    bus_wr = 1'b0; remote_set = '0;
    chk("R6 write wins over set", {63'h0, pin_remote[2]}, 64'h0);
  endtask

  task automatic t_other;
    logic [63:0] v;
    wr(8'h00, 2'd2, 64'h01);
    wr(8'h20, 2'd2, 64'h77);
    rd(8'h00, 2'd2, v); chk("R7 write elsewhere ignored", v, 64'h01);
    rd(8'h20, 2'd2, v); chk("R7 other offset reads 0", v, 64'h0);
    rd(8'h04, 2'd3, v); chk("R7 offset 4 reads 0", v, 64'h0);
  endtask

  task automatic t_size;
    logic [63:0] v;
    wr(8'h00, 2'd2, 64'h10);
    wr(8'h10, 2'd0, 64'hFFFF_FFFF_0001_80FF);
    chk("R8 byte write pulse", {63'h0, chg_valid}, 64'h1);
    chk("R8 byte write new mask", {62'h0, chg_mask, chg_level}, 64'h0);
    chk("R8 pulse pin 0", {59'h0, chg_pin}, 64'd0);
    rd(8'h10, 2'd3, v); chk("R8 byte write stored", v, 64'hFF);
    wr(8'h10, 2'd2, 64'hAAAA_AAAA_1234_5678);
    rd(8'h10, 2'd3, v); chk("R8 word write stored", v, 64'h1234_1678);
    rd(8'h10, 2'd0, v); chk("R8 1-byte read", v, 64'h78);
    rd(8'h10, 2'd1, v); chk("R8 2-byte read", v, 64'h1678);
    wr(8'h00, 2'd2, 64'h11);
    wr(8'h10, 2'd3, 64'h5555_5555_0102_0304);
    rd(8'h10, 2'd3, v); chk("R8 8-byte write low 32 only", v, 64'h0102_0304);
    wr(8'h10, 2'd1, 64'hFFFF_FFFF_FFFF_ABCD);
    rd(8'h10, 2'd2, v); chk("R8 2-byte write", v, 64'hABCD);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_select();
    t_version();
    t_id();
    t_table();
    t_oor();
    t_remote();
    t_other();
    t_size();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule